// File: doc/BRIEF.md
# Loop Counter Branch Unit

This unit carries out a single counted-loop branch step. A mode byte tells it whether to count a register down by one, count it up by one, or only look at it. The same byte picks one of eight registers and says whether the branch is taken when the new value is zero or when it is not. A second byte carries the low eight bits of a signed nine-bit displacement, and the ninth bit of that displacement sits inside the mode byte. The unit is given the address of the next instruction. From it the unit forms the branch target and chooses the next PC.

The register file itself is outside the unit. The unit puts the register number on a read-select output and takes the value back on the same cycle. Registers 0 to 2 are eight bits wide and registers 3 to 7 are sixteen bits wide. All results are captured in one register stage, so they appear on the cycle after an issue pulse. There they form a writeback triple (enable, select, value), a taken flag, the next PC and a flag for a bad encoding.

Top module: `lcb_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears: `done_o`, `wb_en_o`, `taken_o` and `illegal_o` are 0, and `wb_sel_o`, `wb_val_o` and `next_pc_o` are all zero.
- R2: Mode bits [7:6] choose the operation: 2'b00 subtracts one, 2'b01 leaves the value as read, and 2'b10 adds one. The results of an issue appear with `done_o` = 1 on the cycle after `issue_i` is high.
- R3: Registers 0, 1 and 2 are eight bits wide. The count wraps modulo 256, the zero test uses bits [7:0] only, and `wb_val_o[15:8]` is 0 whatever the upper byte of `rf_data_i` holds.
- R4: Registers 3 to 7 are sixteen bits wide. The count wraps modulo 65536 and the zero test uses all sixteen bits.
- R5: Mode bit 5 sets the branch polarity. With bit 5 = 1 the branch is taken when the updated value is non-zero. With bit 5 = 0 it is taken when the updated value is zero.
- R6: When the branch is taken, `next_pc_o` = `pc_i` + D (mod 2^16). D is `disp_i` with mode bit 4 copied into all eight upper bits, so bit 4 = 1 gives a backward displacement.
- R7: When the branch is not taken, `next_pc_o` equals the `pc_i` of that issue.
- R8: For the count-down and count-up operations, `wb_en_o` is 1 whether or not the branch is taken. `wb_sel_o` equals mode bits [2:0] and `wb_val_o` holds the updated value.
- R9: For the look-only operation (2'b01), `wb_en_o` is 0, while the branch decision is still made on the value as read.
- R10: Mode bits [7:6] = 2'b11 set `illegal_o` and clear `wb_en_o` and `taken_o`. `next_pc_o` then equals `pc_i`.
- R11: `rf_sel_o` follows mode bits [2:0] without delay. Mode bit 3 has no effect on any output.
- R12: On a cycle after no issue, `done_o`, `wb_en_o`, `taken_o` and `illegal_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Execute the step this cycle |
| mode_i | input | 8 | Operation, polarity, displacement sign, register select |
| disp_i | input | 8 | Low byte of the displacement |
| pc_i | input | 16 | Address of the next instruction |
| rf_sel_o | output | 3 | Register file read select |
| rf_data_i | input | 16 | Register file read data |
| done_o | output | 1 | Results valid |
| wb_en_o | output | 1 | Writeback enable |
| wb_sel_o | output | 3 | Writeback register |
| wb_val_o | output | 16 | Writeback value |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| illegal_o | output | 1 | Bad operation encoding |

## Verification
The writeback and the branch redirect can happen in the same cycle. A count-down that reaches zero with zero polarity, and an increment wrap that takes a backward branch, both make `wb_en_o` and `taken_o` rise together. The bench judges them in two ways. It compares both against a register model kept in the bench, and it then reads the register back through a look-only step, which shows that the write really landed.

// File: rtl/lcb_pkg.sv
// Package: shared encodings for the loop counter branch unit.
// Assumes an eight-bit mode byte with operation in [7:6].
package lcb_pkg;
    typedef enum logic [1:0] {
        OP_DOWN = 2'b00,
        OP_LOOK = 2'b01,
        OP_UP   = 2'b10,
        OP_BAD  = 2'b11
    } lcb_op_e;

    typedef struct packed {
        lcb_op_e    op;
        logic       on_nonzero;
        logic       disp_neg;
        logic [2:0] sel;
    } lcb_ctl_t;
endpackage

// File: rtl/lcb_decode.sv
// Module: splits the mode byte into control fields and derives the
// register width class and writeback intent. Purely combinational.
// Assumes registers below NARROW_REGS are narrow.
module lcb_decode #(
    parameter int SEL_W       = 3,
    parameter int NARROW_REGS = 3
) (
    input  logic [7:0]       mode,
    output lcb_pkg::lcb_ctl_t ctl,
    output logic             narrow,
    output logic             writes,
    output logic             bad
);
    logic unused_rsvd;

    // field extraction; bit 3 carries no meaning
    always_comb begin
        ctl.op         = lcb_pkg::lcb_op_e'(mode[7:6]);
        ctl.on_nonzero = mode[5];
        ctl.disp_neg   = mode[4];
        ctl.sel        = mode[SEL_W-1:0];
        unused_rsvd    = mode[3];
    end

    // classification of width, writeback and legality
    always_comb begin
        narrow = (int'(ctl.sel) < NARROW_REGS);
        bad    = (ctl.op == lcb_pkg::OP_BAD);
        writes = (ctl.op == lcb_pkg::OP_DOWN) || (ctl.op == lcb_pkg::OP_UP);
    end
endmodule

// File: rtl/lcb_update.sv
// Module: computes the counted value and its zero status, honouring
// the narrow or wide width of the selected register.
// Assumes NARROW_W < DATA_W.
module lcb_update #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] cur,
    input  lcb_pkg::lcb_op_e  op,
    input  logic              narrow,
    output logic [DATA_W-1:0] nxt,
    output logic              is_zero
);
    localparam int HI_W = DATA_W - NARROW_W;
    localparam logic [DATA_W-1:0] NARROW_MASK = {{HI_W{1'b0}}, {NARROW_W{1'b1}}};

    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] sum;

    // step selection: minus one, zero or plus one
    always_comb begin
        unique case (op)
            lcb_pkg::OP_DOWN: step = '1;
            lcb_pkg::OP_UP:   step = DATA_W'(1);
            default:          step = '0;
        endcase
    end

    // addition then truncation to the register width
    always_comb begin
        sum     = cur + step;
        nxt     = narrow ? (sum & NARROW_MASK) : sum;
        is_zero = (nxt == '0);
    end
endmodule

// File: rtl/lcb_target.sv
// Module: forms the branch target from the PC and the nine-bit
// signed displacement (sign supplied separately).
// Assumes ADDR_W > OFS_W.
module lcb_target #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              neg,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFS_W;

    // sign extension and modular add
    always_comb begin
        target = pc + {{EXT_W{neg}}, ofs};
    end
endmodule

// File: rtl/lcb_unit.sv
// Module: top of the loop counter branch unit. Reads one register,
// counts it, decides the branch and registers all results one cycle
// after issue. Assumes register file read data is valid in the
// issue cycle for the select presented on rf_sel_o.
module lcb_unit #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int NARROW_W    = 8,
    parameter int OFS_W       = 8,
    parameter int SEL_W       = 3,
    parameter int NARROW_REGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [7:0]        mode_i,
    input  logic [OFS_W-1:0]  disp_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [SEL_W-1:0]  rf_sel_o,
    input  logic [DATA_W-1:0] rf_data_i,
    output logic              done_o,
    output logic              wb_en_o,
    output logic [SEL_W-1:0]  wb_sel_o,
    output logic [DATA_W-1:0] wb_val_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              illegal_o
);
    lcb_pkg::lcb_ctl_t  ctl;
    logic               narrow, writes, bad;
    logic [DATA_W-1:0]  nxt_val;
    logic               nxt_zero;
    logic [ADDR_W-1:0]  target;
    logic               branch;
    logic [ADDR_W-1:0]  pc_sel;

    lcb_decode #(.SEL_W(SEL_W), .NARROW_REGS(NARROW_REGS)) u_dec (
        .mode(mode_i), .ctl(ctl), .narrow(narrow), .writes(writes), .bad(bad)
    );

    lcb_update #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_upd (
        .cur(rf_data_i), .op(ctl.op), .narrow(narrow),
        .nxt(nxt_val), .is_zero(nxt_zero)
    );

    lcb_target #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_tgt (
        .pc(pc_i), .ofs(disp_i), .neg(ctl.disp_neg), .target(target)
    );

    // read select straight from the mode byte
    assign rf_sel_o = ctl.sel;

    // branch decision and PC choice
    always_comb begin
        branch = !bad && (ctl.on_nonzero ? !nxt_zero : nxt_zero);
        pc_sel = branch ? target : pc_i;
    end

    // result register stage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            wb_en_o   <= 1'b0;
            wb_sel_o  <= '0;
            wb_val_o  <= '0;
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            illegal_o <= 1'b0;
        end else begin
            done_o    <= issue_i;
            wb_en_o   <= issue_i && writes;
            taken_o   <= issue_i && branch;
            illegal_o <= issue_i && bad;
            if (issue_i) begin
                wb_sel_o  <= ctl.sel;
                wb_val_o  <= nxt_val;
                next_pc_o <= pc_sel;
            end
        end
    end
endmodule

// File: rtl/lcb_unit_chk.sv
// Module: property checker for lcb_unit, attached by bind.
module lcb_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [7:0]        mode_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [SEL_W-1:0]  rf_sel_o,
    input logic              done_o,
    input logic              wb_en_o,
    input logic [SEL_W-1:0]  wb_sel_o,
    input logic [DATA_W-1:0] wb_val_o,
    input logic              taken_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic              illegal_o
);
    // R2: results follow an issue by one cycle
    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> done_o);

    // R12: nothing reported without an issue
    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !done_o && !wb_en_o && !taken_o && !illegal_o);

    // R10: a bad encoding neither writes nor branches
    assert_illegal_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wb_en_o && !taken_o);

    // R7: not taken keeps the sequential PC
    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && $past(rst_n)) |=> (taken_o || next_pc_o == $past(pc_i)));

    // R8: writeback register is the selected one
    assert_wb_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> (!wb_en_o || wb_sel_o == $past(mode_i[SEL_W-1:0])));

    // R9: the look-only operation never writes
    assert_look_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && mode_i[7:6] == 2'b01) |=> !wb_en_o);

    // R3: narrow registers carry a clear upper byte
    assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wb_sel_o < 3) |-> wb_val_o[DATA_W-1:8] == '0);

    // R11: read select tracks the mode byte
    always_comb begin
        if (rst_n) begin
            assert_rdsel_R11: assert (rf_sel_o == mode_i[SEL_W-1:0]);
        end
    end
endmodule

bind lcb_unit lcb_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .mode_i(mode_i), .pc_i(pc_i),
    .rf_sel_o(rf_sel_o), .done_o(done_o), .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o),
    .wb_val_o(wb_val_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .illegal_o(illegal_o)
);

// File: tb/sim_lcb_unit.sv
module sim_lcb_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [7:0]  mode_i = 8'h00;
    logic [7:0]  disp_i = 8'h00;
    logic [15:0] pc_i = 16'h0000;
    logic [2:0]  rf_sel_o;
    logic [15:0] rf_data_i;
    logic        done_o, wb_en_o, taken_o, illegal_o;
    logic [2:0]  wb_sel_o;
    logic [15:0] wb_val_o, next_pc_o;

    logic [15:0] regs [8];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lcb_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .mode_i(mode_i),
        .disp_i(disp_i), .pc_i(pc_i), .rf_sel_o(rf_sel_o), .rf_data_i(rf_data_i),
        .done_o(done_o), .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o), .wb_val_o(wb_val_o),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .illegal_o(illegal_o)
    );

    always_comb rf_data_i = regs[rf_sel_o];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one step, compute expectation from the model, check, update the model
    task automatic step(input string req, input logic [7:0] m, input logic [7:0] d,
                        input logic [15:0] pc);
        logic [1:0]  op;
        logic [2:0]  sel;
        logic [15:0] v, nv, tgt;
        logic        nar, br, wr, bad;
        op  = m[7:6];
        sel = m[2:0];
        nar = (sel < 3);
        v   = nar ? {8'h00, regs[sel][7:0]} : regs[sel];
        nv  = (op == 2'b00) ? v - 16'd1 : (op == 2'b10) ? v + 16'd1 : v;
        if (nar) nv = {8'h00, nv[7:0]};
        bad = (op == 2'b11);
        br  = !bad && (m[5] ? (nv != 0) : (nv == 0));
        wr  = (op == 2'b00) || (op == 2'b10);
        tgt = pc + {{8{m[4]}}, d};
        @(negedge clk);
        issue_i = 1'b1; mode_i = m; disp_i = d; pc_i = pc;
        #1 chk({req, " R11 rdsel"}, 32'(rf_sel_o), 32'(sel));
        @(negedge clk);
        issue_i = 1'b0;
        chk({req, " R2 done"}, 32'(done_o), 1);
        chk({req, " R10 illegal"}, 32'(illegal_o), 32'(bad));
        chk({req, " R8/R9 wb_en"}, 32'(wb_en_o), 32'(wr));
        chk({req, " R5 taken"}, 32'(taken_o), 32'(br));
        chk({req, " R6/R7 next_pc"}, 32'(next_pc_o), 32'(br ? tgt : pc));
        if (!bad) begin
            chk({req, " R8 wb_sel"}, 32'(wb_sel_o), 32'(sel));
            chk({req, " R3/R4 wb_val"}, 32'(wb_val_o), 32'(nv));
        end
        if (wr) regs[sel] = nv;
    endtask

    task automatic t_reset();
        chk("R1 done", 32'(done_o), 0);
        chk("R1 wb_en", 32'(wb_en_o), 0);
        chk("R1 taken", 32'(taken_o), 0);
        chk("R1 illegal", 32'(illegal_o), 0);
        chk("R1 next_pc", 32'(next_pc_o), 0);
        chk("R1 wb_val", 32'(wb_val_o), 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R12 done", 32'(done_o), 0);
        chk("R12 wb_en", 32'(wb_en_o), 0);
        chk("R12 taken", 32'(taken_o), 0);
        chk("R12 illegal", 32'(illegal_o), 0);
    endtask

    // count down to zero with zero polarity: write and branch together
    task automatic t_down_to_zero();
        regs[1] = 16'h0001;
        step("R2 down B", 8'b0001_0001, 8'hF0, 16'h1000);
        chk("R6 backward target", 32'(next_pc_o), 32'h0FF0);
        step("R9 look B readback", 8'b0110_0001, 8'h10, 16'h2000);
    endtask

    // narrow wrap below zero and upper byte masking
    task automatic t_narrow();
        regs[0] = 16'h5501;
        step("R3 down A upper ignored", 8'b0000_1000, 8'h22, 16'h3000);
        regs[2] = 16'hAB00;
        step("R3 down CCR wraps", 8'b0010_0010, 8'h7F, 16'h4000);
        chk("R3 wb_val 00FF", 32'(wb_val_o), 32'h00FF);
        regs[0] = 16'h00FF;
        step("R3 up A wraps to zero", 8'b1000_0000, 8'h04, 16'h4100);
    endtask

    // wide wrap and polarity of nonzero
    task automatic t_wide();
        regs[5] = 16'hFFFF;
        step("R4 up X wraps", 8'b1001_0101, 8'h80, 16'h0100);
        chk("R4 wb_val 0000", 32'(wb_val_o), 0);
        regs[6] = 16'h0100;
        step("R4 down Y nonzero branch", 8'b0010_0110, 8'h05, 16'h5000);
        regs[7] = 16'h0000;
        step("R4 down SP wraps", 8'b0000_0111, 8'h05, 16'h6000);
        regs[3] = 16'h1234;
        step("R9 look temp", 8'b0100_0011, 8'h01, 16'hFFFF);
        regs[4] = 16'h0000;
        step("R5 look D zero pol", 8'b0101_0100, 8'hFE, 16'h0001);
    endtask

    task automatic t_illegal();
        regs[4] = 16'h0000;
        step("R10 bad op", 8'b1101_0100, 8'h10, 16'h7000);
        step("R10 D untouched", 8'b0100_0100, 8'h00, 16'h7100);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_down_to_zero();
        t_idle();
        t_narrow();
        t_wide();
        t_illegal();
        t_idle();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule